// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block keeps the instruction address for a small core with 14-bit instruction words. It holds a 13-bit program counter, which covers 8K instruction words, and a page latch that supplies the upper address bits when software writes the low byte of the counter. It also holds an eight-slot return stack. Each cycle the instruction decoder sends at most a few single-cycle strobes: advance, jump, call, interrupt entry, return, low-byte write and latch write. The block resolves them by a fixed priority and updates the counter on the next clock edge.

The return stack is a ring with no visible pointer. Calls and interrupt entries save the address of the next sequential instruction, and returns restore the most recent saved address. When a ninth address is saved, it replaces the oldest one without any warning. A return with nothing saved reads whatever the slot below the pointer holds. None of the control inputs carries a data stream, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure. The decoder reads the current address on `pc_o`. It reads the low-byte and latch view on `pc_lo_o` and `page_o`.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_o`, `pc_lo_o` and `page_o` are zero and all eight stack slots are cleared, so a return issued before any save loads 0.
- R2: The advance strobe alone sets `pc_o` to the previous value plus one, modulo 8192 (0x1FFF advances to 0x0000).
- R3: Interrupt entry loads `pc_o` with 0x0004 and saves the previous `pc_o` plus one on the stack.
- R4: A low-byte write loads `pc_o` with {stored `page_o`[4:0], `lo_wdata_i`[7:0]}, where bit 12 is the latch's bit 4. A latch write in the same cycle does not affect this result.
- R5: A jump or a call loads `pc_o` with {stored `page_o`[4:3], `tgt_i`[10:0]}, with latch bits 4:3 becoming `pc_o` bits 12:11.
- R6: A call saves the previous `pc_o` plus one, and a later return restores saved values in last-in, first-out order.
- R7: The stack has eight slots used as a ring. After nine saves, the first is lost and the ninth occupies its slot, so nine returns yield the 9th, 8th, ..., 2nd saved values and then the 9th again.
- R8: The stack pointer wraps modulo 8 in both directions. A return with no saved entry loads the contents of the slot just below the pointer.
- R9: `page_o` changes only on the latch write strobe (taking `page_wdata_i`) and is unaffected by saves, restores, jumps and low-byte writes. `pc_lo_o` always equals `pc_o`[7:0].
- R10: Simultaneous strobes resolve as interrupt > call > jump > return > low-byte write > advance. Only the winner acts on the counter and stack, and with no strobe the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance to the next sequential instruction |
| jmp_i | input | 1 | Absolute jump to the target |
| call_i | input | 1 | Call: save return address, jump to the target |
| irq_i | input | 1 | Interrupt entry: save return address, go to 0x0004 |
| ret_i | input | 1 | Return: restore the most recent saved address |
| tgt_i | input | 11 | Target field taken from the instruction word |
| lo_we_i | input | 1 | Write strobe for the low counter byte |
| lo_wdata_i | input | 8 | Data for the low counter byte |
| page_we_i | input | 1 | Write strobe for the page latch |
| page_wdata_i | input | 5 | Data for the page latch |
| pc_o | output | 13 | Current program counter |
| pc_lo_o | output | 8 | Low byte of the counter, as read by software |
| page_o | output | 5 | Page latch contents |

## Verification
The assertions assume that every strobe is sampled only after reset has been released for a cycle. They also assume that the call-then-return property sees a return with no competing interrupt, call or jump. Under those conditions, each property compares the counter against the strobe that won in the previous cycle. The bench drives every input at the falling edge and holds all strobes low during reset. It also drives each strobe as a one-cycle pulse, so the properties only ever see legal, fully resolved cycles. The priority combinations, ring overflow and empty pops are all produced through these same pulses.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;

  // winning operation of a cycle, listed from lowest to highest priority
  typedef enum logic [2:0] {
    PCOP_HOLD,
    PCOP_STEP,
    PCOP_LOWR,
    PCOP_RET,
    PCOP_JMP,
    PCOP_CALL,
    PCOP_IRQ
  } pc_op_e;

  function automatic logic op_saves(input pc_op_e op);
    return (op == PCOP_CALL) || (op == PCOP_IRQ);
  endfunction

endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pc_sequencer_pkg::*;
(
  input  logic   step_i,
  input  logic   jmp_i,
  input  logic   call_i,
  input  logic   irq_i,
  input  logic   ret_i,
  input  logic   lo_we_i,
  output pc_op_e op_o
);

  always_comb begin
    if (irq_i)        op_o = PCOP_IRQ;
    else if (call_i)  op_o = PCOP_CALL;
    else if (jmp_i)   op_o = PCOP_JMP;
    else if (ret_i)   op_o = PCOP_RET;
    else if (lo_we_i) op_o = PCOP_LOWR;
    else if (step_i)  op_o = PCOP_STEP;
    else              op_o = PCOP_HOLD;
  end

endmodule

// File: rtl/pcs_latch.sv
module pcs_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

endmodule

// File: rtl/pcs_ring.sv
module pcs_ring #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] below;
  logic [W-1:0]    slot [DEPTH];

  // index arithmetic wraps naturally because DEPTH is a power of two
  assign below = sp_q - 1'b1;
  assign top_o = slot[below];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= below;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot[i] <= '0;
      else if (push_i && (sp_q == SP_W'(i)))     slot[i] <= push_data_i;
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_sequencer_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int TGT_W   = 11,
  parameter int DEPTH   = 8,
  parameter int IRQ_VEC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                jmp_i,
  input  logic                call_i,
  input  logic                irq_i,
  input  logic                ret_i,
  input  logic [TGT_W-1:0]    tgt_i,
  input  logic                lo_we_i,
  input  logic [LO_W-1:0]     lo_wdata_i,
  input  logic                page_we_i,
  input  logic [PC_W-LO_W-1:0] page_wdata_i,
  output logic [PC_W-1:0]     pc_o,
  output logic [LO_W-1:0]     pc_lo_o,
  output logic [PC_W-LO_W-1:0] page_o
);

  localparam int HI_W   = PC_W - LO_W;
  localparam int PAGE_W = PC_W - TGT_W;

  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, ret_addr;
  logic [HI_W-1:0] page_q;

  pcs_arbiter u_arb (
    .step_i  (step_i),
    .jmp_i   (jmp_i),
    .call_i  (call_i),
    .irq_i   (irq_i),
    .ret_i   (ret_i),
    .lo_we_i (lo_we_i),
    .op_o    (op)
  );

  pcs_latch #(.W(HI_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (page_we_i),
    .wdata_i (page_wdata_i),
    .q_o     (page_q)
  );

  pcs_ring #(.DEPTH(DEPTH), .W(PC_W)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (op_saves(op)),
    .pop_i       (op == PCOP_RET),
    .push_data_i (pc_inc),
    .top_o       (ret_addr)
  );

  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    unique case (op)
      PCOP_IRQ:            pc_d = PC_W'(IRQ_VEC);
      PCOP_CALL, PCOP_JMP: pc_d = {page_q[HI_W-1 -: PAGE_W], tgt_i};
      PCOP_RET:            pc_d = ret_addr;
      PCOP_LOWR:           pc_d = {page_q, lo_wdata_i};
      PCOP_STEP:           pc_d = pc_inc;
      default:             pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o    = pc_q;
  assign pc_lo_o = pc_q[LO_W-1:0];
  assign page_o  = page_q;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int PC_W    = 13,
  parameter int LO_W    = 8,
  parameter int TGT_W   = 11,
  parameter int DEPTH   = 8,
  parameter int IRQ_VEC = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 step_i,
  input logic                 jmp_i,
  input logic                 call_i,
  input logic                 irq_i,
  input logic                 ret_i,
  input logic [TGT_W-1:0]     tgt_i,
  input logic                 lo_we_i,
  input logic [LO_W-1:0]      lo_wdata_i,
  input logic                 page_we_i,
  input logic [PC_W-LO_W-1:0] page_wdata_i,
  input logic [PC_W-1:0]      pc_o,
  input logic [LO_W-1:0]      pc_lo_o,
  input logic [PC_W-LO_W-1:0] page_o
);

  localparam int HI_W   = PC_W - LO_W;
  localparam int PAGE_W = PC_W - TGT_W;

  logic any_ctl;
  assign any_ctl = irq_i || call_i || jmp_i || ret_i || lo_we_i;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !any_ctl) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  p_irq_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> pc_o == PC_W'(IRQ_VEC));

  p_lowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we_i && !(irq_i || call_i || jmp_i || ret_i))
      |=> pc_o == {$past(page_o), $past(lo_wdata_i)});

  p_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((jmp_i || call_i) && !irq_i)
      |=> pc_o == {$past(page_o[HI_W-1 -: PAGE_W]), $past(tgt_i)});

  p_call_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(call_i && !irq_i) && ret_i && !irq_i && !call_i && !jmp_i)
      |=> pc_o == PC_W'($past(pc_o, 2) + 1'b1));

  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we_i |=> $stable(page_o));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(any_ctl || step_i) |=> $stable(pc_o));

endmodule

bind pc_sequencer pc_sequencer_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .DEPTH(DEPTH), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 0, jmp_i = 0, call_i = 0, irq_i = 0, ret_i = 0;
  logic [10:0] tgt_i = '0;
  logic        lo_we_i = 0;
  logic [7:0]  lo_wdata_i = '0;
  logic        page_we_i = 0;
  logic [4:0]  page_wdata_i = '0;
  logic [12:0] pc_o;
  logic [7:0]  pc_lo_o;
  logic [4:0]  page_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic [12:0] m_pc;
  logic [4:0]  m_page;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp;

  always #2.5 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk, .rst_n, .step_i, .jmp_i, .call_i, .irq_i, .ret_i, .tgt_i,
    .lo_we_i, .lo_wdata_i, .page_we_i, .page_wdata_i,
    .pc_o, .pc_lo_o, .page_o
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "pc", int'(pc_o), int'(m_pc));
    chk(req, "pc_lo", int'(pc_lo_o), int'(m_pc[7:0]));
    chk(req, "page", int'(page_o), int'(m_page));
  endtask

  task automatic cyc(input logic s, input logic j, input logic c, input logic i,
                     input logic r, input logic lw, input logic [7:0] ld,
                     input logic hw, input logic [4:0] hd, input logic [10:0] t,
                     input string req);
    step_i = s; jmp_i = j; call_i = c; irq_i = i; ret_i = r;
    lo_we_i = lw; lo_wdata_i = ld; page_we_i = hw; page_wdata_i = hd; tgt_i = t;
    if (i) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; m_pc = 13'h0004;
    end else if (c) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; m_pc = {m_page[4:3], t};
    end else if (j) begin
      m_pc = {m_page[4:3], t};
    end else if (r) begin
      m_sp = m_sp - 3'd1; m_pc = m_stk[m_sp];
    end else if (lw) begin
      m_pc = {m_page, ld};
    end else if (s) begin
      m_pc = m_pc + 13'd1;
    end
    if (hw) m_page = hd;
    @(posedge clk);
    @(negedge clk);
    step_i = 0; jmp_i = 0; call_i = 0; irq_i = 0; ret_i = 0;
    lo_we_i = 0; page_we_i = 0;
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_pc = '0; m_page = '0; m_sp = '0;
    for (int k = 0; k < 8; k++) m_stk[k] = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R8 / R1: return with nothing saved reads the cleared slot below the pointer
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R8");
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R8");

    // R2: sequential advance
    for (int k = 0; k < 40; k++) cyc(1,0,0,0,0,0,8'h00,0,5'h00,11'h000,"R2");
    // R10: idle holds
    cyc(0,0,0,0,0,0,8'h00,0,5'h00,11'h000,"R10");

    // R4 + R2: low-byte write to top of space then wrap
    cyc(0,0,0,0,0,0,8'h00,1,5'h1F,11'h000,"R9");
    cyc(0,0,0,0,0,1,8'hFF,0,5'h00,11'h000,"R4");
    cyc(1,0,0,0,0,0,8'h00,0,5'h00,11'h000,"R2");
    // R4: concurrent latch write uses stored latch
    cyc(0,0,0,0,0,1,8'h5A,1,5'h03,11'h000,"R4");
    cyc(0,0,0,0,0,1,8'hA5,0,5'h00,11'h000,"R4");

    // R5: sweep every latch value, jump and low write per value
    for (int h = 0; h < 32; h++) begin
      cyc(0,0,0,0,0,0,8'h00,1,5'(h),11'h000,"R9");
      cyc(0,1,0,0,0,0,8'h00,0,5'h00,11'((h * 37 + 5) % 2048),"R5");
      cyc(0,0,0,0,0,1,8'((h * 11) % 256),0,5'h00,11'h000,"R4");
    end

    // R6 / R7: eleven nested calls overflow the ring, then eleven returns
    for (int k = 0; k < 11; k++) begin
      cyc(1,0,0,0,0,0,8'h00,0,5'h00,11'h000,"R2");
      cyc(0,0,1,0,0,0,8'h00,(k == 4),5'h10,11'(k * 100 + 3),"R6");
    end
    for (int k = 0; k < 11; k++) cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R7");
    // R8: keep popping past the saved entries
    for (int k = 0; k < 6; k++) cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R8");

    // R3: interrupt entry, then return to interrupted flow
    cyc(0,1,0,0,0,0,8'h00,0,5'h00,11'h2AB,"R5");
    cyc(0,0,0,1,0,0,8'h00,0,5'h00,11'h000,"R3");
    cyc(1,0,0,0,0,0,8'h00,0,5'h00,11'h000,"R2");
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R3");

    // R10: priority combinations
    cyc(1,1,1,1,1,1,8'h77,0,5'h00,11'h111,"R10");
    cyc(1,1,1,0,1,1,8'h77,0,5'h00,11'h222,"R10");
    cyc(1,1,0,0,1,1,8'h77,0,5'h00,11'h333,"R10");
    cyc(1,0,0,0,1,1,8'h77,0,5'h00,11'h000,"R10");
    cyc(1,0,0,0,0,1,8'h66,0,5'h00,11'h000,"R10");
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R10");
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R10");

    // R9: latch unaffected by saves and restores
    cyc(0,0,0,0,0,0,8'h00,1,5'h15,11'h000,"R9");
    cyc(0,0,1,0,0,0,8'h00,0,5'h00,11'h444,"R9");
    cyc(0,0,0,1,0,0,8'h00,0,5'h00,11'h000,"R9");
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R9");
    cyc(0,0,0,0,1,0,8'h00,0,5'h00,11'h000,"R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule